// File: doc/BRIEF.md
# Six-Step Complementary Commutation PWM Controller

This block drives a three-phase power stage built from three half bridges. Each half bridge takes one PWM input and one active-low reset that places it in high impedance. The block reads a 3-bit Hall position code and turns it into one of six commutation steps. In each step one phase sources current, one phase sinks it, and the third floats. The Hall-code-to-step table can be reprogrammed, because the sensor order depends on the motor. A signed command sets the drive strength, and its sign sets the direction of rotation.

In the default complementary mode, the sourcing and sinking phases switch with duties that mirror each other around 50%. A zero command therefore gives a 50% duty on both phases and no net current. In two-quadrant mode only the sourcing phase switches, and the sinking phase holds its low side on. Every period keeps a low-side pulse of at least a programmed length, so that the bootstrap capacitors can recharge. All values that shape the outputs are captured at the end of a PWM period, so a period never mixes two settings.

Top module: `sixstep_pwm_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `pwm_o` and `hb_on_o` are all zero until a valid Hall code has been accepted. A phase is in high impedance whenever its `hb_on_o` bit is 0.
- R2: For a valid step s, phase indices are 0=A, 1=B, 2=C, and the (source, sink) pairs are s0=(A,B), s1=(A,C), s2=(B,C), s3=(B,A), s4=(C,A), s5=(C,B). Exactly these two phases have `hb_on_o` set, and the third phase has `pwm_o` low.
- R3: In complementary mode (`two_quad_i`=0), let P=`period_i`+1 and m=|cmd|. The source phase is high for floor(P*(2^(CMD_W-1)+m)/2^CMD_W) cycles of each period, and the sink phase is high for P minus that value. A zero command gives floor(P/2) on the source phase.
- R4: The source high time never exceeds P-`min_low_i`. No phase's `pwm_o` stays high for a whole period.
- R5: A negative command swaps the source and sink roles of the active pair. The magnitude of the most negative command saturates to 2^(CMD_W-1)-1.
- R6: In two-quadrant mode the source phase is high for min(floor(P*m/2^(CMD_W-1)), P-`min_low_i`) cycles per period. The sink phase is enabled with `pwm_o` held low, and the third phase floats.
- R7: The step table has entries for Hall codes 1 to 6 and resets to step = code-1. A write (`map_wr_i`=1) stores `map_step_i` into the entry for `map_code_i`.
- R8: Hall codes 3'b000 and 3'b111, and table entries greater than 5, are faults: all three `hb_on_o` and `pwm_o` bits are 0.
- R9: The Hall input passes through a two-flop synchronizer. A new code is accepted only after it has been seen unchanged on `filt_len_i`+2 consecutive synchronized samples. A shorter pulse has no effect on the outputs.
- R10: The step, the direction and the duty values take effect only at a PWM counter wrap. `hb_on_o` changes only in the cycle after the counter has returned to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_i | input | CNT_W | PWM period minus one, in clock cycles |
| min_low_i | input | CNT_W | Minimum low-side cycles per period |
| cmd_i | input | CMD_W | Signed current command |
| two_quad_i | input | 1 | 1 selects two-quadrant mode |
| hall_i | input | 3 | Raw Hall sensor code |
| filt_len_i | input | FILT_W | Hall debounce length |
| map_wr_i | input | 1 | Step table write strobe |
| map_code_i | input | 3 | Hall code whose entry is written |
| map_step_i | input | 3 | Step value written |
| pwm_o | output | 3 | Per-phase PWM, 1 = high side on |
| hb_on_o | output | 3 | Per-phase active-low reset drive, 0 = high impedance |

## Verification
The checker watches four properties on every cycle. Either zero or exactly two half bridges are enabled. No disabled phase is driven high. No phase stays high for a full period. The enable pattern changes only right after a counter wrap. The exact duty counts, the role swap on a negative command, the two-quadrant pattern, table reprogramming, fault codes and the rejection of short Hall glitches are shown only by the bench. For these, the bench counts high cycles over a whole period after each setting and compares them with values it computes itself.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  // Phase index: 0 = A, 1 = B, 2 = C
  typedef logic [1:0] phase_t;

  typedef struct packed {
    logic   valid;
    phase_t src;
    phase_t snk;
  } roles_t;

  // Fixed source/sink pair for each commutation step
  function automatic roles_t step_roles(input logic [2:0] step);
    roles_t r;
    r.valid = 1'b1;
    case (step)
      3'd0:    begin r.src = 2'd0; r.snk = 2'd1; end
      3'd1:    begin r.src = 2'd0; r.snk = 2'd2; end
      3'd2:    begin r.src = 2'd1; r.snk = 2'd2; end
      3'd3:    begin r.src = 2'd1; r.snk = 2'd0; end
      3'd4:    begin r.src = 2'd2; r.snk = 2'd0; end
      3'd5:    begin r.src = 2'd2; r.snk = 2'd1; end
      default: begin r.valid = 1'b0; r.src = 2'd3; r.snk = 2'd3; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sixstep_hall_filter.sv
module sixstep_hall_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        hall_i,
  input  logic [FILT_W-1:0] filt_len_i,
  output logic [2:0]        hall_o
);

  logic [2:0]        sy1_q, sy2_q, sy3_q;
  logic [2:0]        stab_q, stab_d;
  logic [FILT_W-1:0] run_q, run_d;

  // Accept a candidate once it has stayed unchanged long enough
  always_comb begin
    stab_d = stab_q;
    run_d  = '0;
    if ((sy2_q != stab_q) && (sy2_q == sy3_q)) begin
      if (run_q == filt_len_i) begin
        stab_d = sy2_q;
      end else begin
        run_d = run_q + FILT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q  <= 3'b000;
      sy2_q  <= 3'b000;
      sy3_q  <= 3'b000;
      stab_q <= 3'b000;
      run_q  <= '0;
    end else begin
      sy1_q  <= hall_i;
      sy2_q  <= sy1_q;
      sy3_q  <= sy2_q;
      stab_q <= stab_d;
      run_q  <= run_d;
    end
  end

  assign hall_o = stab_q;

endmodule

// File: rtl/sixstep_step_map.sv
module sixstep_step_map
  import sixstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [2:0] code_i,
  input  logic [2:0] step_i,
  input  logic [2:0] hall_i,
  input  logic       rev_i,
  output roles_t     roles_o
);

  logic [2:0] tbl_q [6];
  logic [2:0] tbl_d [6];
  logic       wr_ok;
  logic [2:0] cur_step;
  roles_t     base;

  assign wr_ok = wr_i && (code_i != 3'd0) && (code_i != 3'd7);

  always_comb begin
    tbl_d = tbl_q;
    if (wr_ok) begin
      tbl_d[code_i - 3'd1] = step_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        tbl_q[i] <= 3'(i);
      end
    end else begin
      tbl_q <= tbl_d;
    end
  end

  always_comb begin
    if ((hall_i == 3'd0) || (hall_i == 3'd7)) begin
      cur_step = 3'd7;
    end else begin
      cur_step = tbl_q[hall_i - 3'd1];
    end
    base    = step_roles(cur_step);
    roles_o = base;
    if (rev_i) begin
      roles_o.src = base.snk;
      roles_o.snk = base.src;
    end
  end

endmodule

// File: rtl/sixstep_duty_calc.sv
module sixstep_duty_calc #(
  parameter int CNT_W = 10,
  parameter int CMD_W = 10
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] min_low_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             two_quad_i,
  output logic [CNT_W:0]   src_on_o,
  output logic [CNT_W:0]   snk_on_o,
  output logic             rev_o
);

  localparam int PLEN_W = CNT_W + 1;
  localparam int PROD_W = PLEN_W + CMD_W;
  localparam logic [CMD_W-1:0] MAG_MAX = {1'b0, {(CMD_W-1){1'b1}}};

  logic [CMD_W-1:0]  abs_v, mag;
  logic [PLEN_W-1:0] plen, ml_ext, hi_max;
  logic [PROD_W-1:0] comp_prod, tq_prod;
  logic [PLEN_W-1:0] comp_raw, tq_raw, raw, src_v;

  always_comb begin
    abs_v  = cmd_i[CMD_W-1] ? (~cmd_i + CMD_W'(1)) : cmd_i;
    mag    = (abs_v > MAG_MAX) ? MAG_MAX : abs_v;
    plen   = {1'b0, period_i} + PLEN_W'(1);
    ml_ext = {1'b0, min_low_i};

    // half scale plus magnitude, scaled to the period
    comp_prod = PROD_W'(plen) * PROD_W'({1'b1, mag[CMD_W-2:0]});
    tq_prod   = PROD_W'(plen) * PROD_W'(mag);
    comp_raw  = PLEN_W'(comp_prod >> CMD_W);
    tq_raw    = PLEN_W'(tq_prod >> (CMD_W - 1));
    raw       = two_quad_i ? tq_raw : comp_raw;

    hi_max   = (plen > ml_ext) ? (plen - ml_ext) : '0;
    src_v    = (raw > hi_max) ? hi_max : raw;
    src_on_o = src_v;
    snk_on_o = two_quad_i ? '0 : (plen - src_v);
  end

  assign rev_o = cmd_i[CMD_W-1];

endmodule

// File: rtl/sixstep_timebase.sv
module sixstep_timebase
  import sixstep_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  roles_t           roles_i,
  input  logic [CNT_W:0]   src_on_i,
  input  logic [CNT_W:0]   snk_on_i,
  output logic [2:0]       pwm_o,
  output logic [2:0]       hb_on_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;
  roles_t           sh_roles_q;
  logic [CNT_W:0]   sh_src_q, sh_snk_q;
  logic [CNT_W:0]   cnt_ext;
  logic [2:0]       pwm_d, hb_d, pwm_q, hb_q;

  assign wrap    = (cnt_q >= period_i);
  assign cnt_d   = wrap ? '0 : (cnt_q + CNT_W'(1));
  assign cnt_ext = {1'b0, cnt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Shadow registers loaded only at wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_roles_q <= '0;
      sh_src_q   <= '0;
      sh_snk_q   <= '0;
    end else if (wrap) begin
      sh_roles_q <= roles_i;
      sh_src_q   <= src_on_i;
      sh_snk_q   <= snk_on_i;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_phase
    logic is_src, is_snk;
    assign is_src   = sh_roles_q.valid && (sh_roles_q.src == phase_t'(g));
    assign is_snk   = sh_roles_q.valid && (sh_roles_q.snk == phase_t'(g));
    assign pwm_d[g] = (is_src && (cnt_ext < sh_src_q)) ||
                      (is_snk && (cnt_ext < sh_snk_q));
    assign hb_d[g]  = is_src || is_snk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 3'b000;
      hb_q  <= 3'b000;
    end else begin
      pwm_q <= pwm_d;
      hb_q  <= hb_d;
    end
  end

  assign pwm_o   = pwm_q;
  assign hb_on_o = hb_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/sixstep_pwm_ctrl.sv
module sixstep_pwm_ctrl
  import sixstep_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int CMD_W  = 10,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  min_low_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              two_quad_i,
  input  logic [2:0]        hall_i,
  input  logic [FILT_W-1:0] filt_len_i,
  input  logic              map_wr_i,
  input  logic [2:0]        map_code_i,
  input  logic [2:0]        map_step_i,
  output logic [2:0]        pwm_o,
  output logic [2:0]        hb_on_o
);

  logic [1:0]       rst_pipe_q;
  logic             srst_n;
  logic [2:0]       hall_stab;
  logic             rev;
  roles_t           roles;
  logic [CNT_W:0]   src_on, snk_on;
  logic [CNT_W-1:0] pwm_cnt;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe_q[1];

  sixstep_hall_filter #(.FILT_W(FILT_W)) filt_i (
    .clk        (clk),
    .rst_n      (srst_n),
    .hall_i     (hall_i),
    .filt_len_i (filt_len_i),
    .hall_o     (hall_stab)
  );

  sixstep_duty_calc #(.CNT_W(CNT_W), .CMD_W(CMD_W)) duty_i (
    .period_i   (period_i),
    .min_low_i  (min_low_i),
    .cmd_i      (cmd_i),
    .two_quad_i (two_quad_i),
    .src_on_o   (src_on),
    .snk_on_o   (snk_on),
    .rev_o      (rev)
  );

  sixstep_step_map map_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_i    (map_wr_i),
    .code_i  (map_code_i),
    .step_i  (map_step_i),
    .hall_i  (hall_stab),
    .rev_i   (rev),
    .roles_o (roles)
  );

  sixstep_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk      (clk),
    .rst_n    (srst_n),
    .period_i (period_i),
    .roles_i  (roles),
    .src_on_i (src_on),
    .snk_on_i (snk_on),
    .pwm_o    (pwm_o),
    .hb_on_o  (hb_on_o),
    .cnt_o    (pwm_cnt)
  );

endmodule

// File: rtl/sixstep_pwm_chk.sv
module sixstep_pwm_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       pwm_o,
  input logic [2:0]       hb_on_o,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] cnt_i
);

  // R2
  hb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hb_on_o) == 0) || ($countones(hb_on_o) == 2));

  // R2
  pwm_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o & ~hb_on_o) == 3'b000);

  // R10
  wrap_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hb_on_o) |-> ($past(cnt_i) == '0));

  for (genvar g = 0; g < 3; g++) begin : g_run
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= '0;
      end else begin
        run_q <= pwm_o[g] ? (run_q + (CNT_W+1)'(1)) : '0;
      end
    end
    // R4
    min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_o[g] |-> (run_q < {1'b0, period_i}));
  end

endmodule

bind sixstep_pwm_ctrl sixstep_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_o    (pwm_o),
  .hb_on_o  (hb_on_o),
  .period_i (period_i),
  .cnt_i    (pwm_cnt)
);

// File: tb/sixstep_pwm_ctrl_tb.sv
module sixstep_pwm_ctrl_tb_top;

  localparam int CNT_W  = 10;
  localparam int CMD_W  = 10;
  localparam int FILT_W = 4;

  logic              clk;
  logic              rst_n;
  logic [CNT_W-1:0]  period_i;
  logic [CNT_W-1:0]  min_low_i;
  logic [CMD_W-1:0]  cmd_i;
  logic              two_quad_i;
  logic [2:0]        hall_i;
  logic [FILT_W-1:0] filt_len_i;
  logic              map_wr_i;
  logic [2:0]        map_code_i;
  logic [2:0]        map_step_i;
  logic [2:0]        pwm_o;
  logic [2:0]        hb_on_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int plen = 50;
  int tb_map [8];
  int src_of [6] = '{0, 0, 1, 1, 2, 2};
  int snk_of [6] = '{1, 2, 2, 0, 0, 1};
  int e_hb;
  int e_cnt [3];

  sixstep_pwm_ctrl #(.CNT_W(CNT_W), .CMD_W(CMD_W), .FILT_W(FILT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .min_low_i(min_low_i),
    .cmd_i(cmd_i), .two_quad_i(two_quad_i), .hall_i(hall_i),
    .filt_len_i(filt_len_i), .map_wr_i(map_wr_i), .map_code_i(map_code_i),
    .map_step_i(map_step_i), .pwm_o(pwm_o), .hb_on_o(hb_on_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected outputs computed from the requirements
  task automatic compute_exp(input int code, input int c, input int tq, input int ml);
    int step, s, k, mag, raw, him, so, sk, t;
    e_hb = 0;
    for (int i = 0; i < 3; i++) e_cnt[i] = 0;
    if (code == 0 || code == 7) return;          // R8
    step = tb_map[code];
    if (step > 5) return;                        // R8
    s = src_of[step];
    k = snk_of[step];
    if (c < 0) begin t = s; s = k; k = t; end    // R5
    mag = (c < 0) ? -c : c;
    if (mag > 511) mag = 511;
    if (tq != 0) raw = (plen * mag) / 512;       // R6
    else raw = (plen * (512 + mag)) / 1024;      // R3
    him = (plen > ml) ? plen - ml : 0;           // R4
    so = (raw > him) ? him : raw;
    sk = (tq != 0) ? 0 : plen - so;
    e_hb = (1 << s) | (1 << k);
    e_cnt[s] = so;
    e_cnt[k] = sk;
  endtask

  task automatic run_case(input int code, input int c, input int tq, input int ml, input string req);
    int hcnt [3];
    int bad;
    int last_hb;
    @(negedge clk);
    hall_i = 3'(code);
    cmd_i = CMD_W'(c);
    two_quad_i = (tq != 0);
    min_low_i = CNT_W'(ml);
    compute_exp(code, c, tq, ml);
    repeat (3 * plen + 30) @(negedge clk);
    for (int i = 0; i < 3; i++) hcnt[i] = 0;
    bad = 0;
    last_hb = int'(hb_on_o);
    for (int n = 0; n < plen; n++) begin
      @(negedge clk);
      if (int'(hb_on_o) != e_hb) begin bad++; last_hb = int'(hb_on_o); end
      for (int i = 0; i < 3; i++) if (pwm_o[i]) hcnt[i]++;
    end
    check(bad == 0, {req, " enables"}, last_hb, e_hb);
    for (int i = 0; i < 3; i++)
      check(hcnt[i] == e_cnt[i], {req, " high count"}, hcnt[i], e_cnt[i]);
  endtask

  task automatic write_map(input int code, input int step);
    @(negedge clk);
    map_wr_i = 1'b1;
    map_code_i = 3'(code);
    map_step_i = 3'(step);
    @(negedge clk);
    map_wr_i = 1'b0;
    tb_map[code] = step;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) tb_map[i] = i - 1;
    rst_n = 1'b0;
    period_i = CNT_W'(plen - 1);
    min_low_i = '0;
    cmd_i = '0;
    two_quad_i = 1'b0;
    hall_i = 3'd0;
    filt_len_i = FILT_W'(3);
    map_wr_i = 1'b0;
    map_code_i = '0;
    map_step_i = '0;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(pwm_o == 3'b000, "R1 pwm in reset", int'(pwm_o), 0);
    check(hb_on_o == 3'b000, "R1 enables in reset", int'(hb_on_o), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(hb_on_o == 3'b000 && pwm_o == 3'b000, "R1 after release", int'(hb_on_o), 0);

    // R8: fault codes
    run_case(0, 100, 0, 2, "R8 code 000");
    run_case(7, 100, 0, 2, "R8 code 111");

    // R2 R3: every step at zero command
    for (int code = 1; code <= 6; code++) run_case(code, 0, 0, 2, "R2 R3 step zero cmd");

    // R3 R5: positive and negative commands
    run_case(2, 200, 0, 2, "R3 cmd +200");
    run_case(2, -200, 0, 2, "R5 cmd -200");
    // R4: clamp near full scale, most negative command saturates
    run_case(3, 511, 0, 5, "R4 clamp +511");
    run_case(5, -512, 0, 5, "R4 R5 clamp -512");
    run_case(6, 511, 0, 0, "R4 no min low");

    // R6: two-quadrant
    run_case(1, 300, 1, 2, "R6 two quad +300");
    run_case(4, -511, 1, 4, "R6 two quad clamp");

    // R7 R8: table programming
    write_map(1, 3);
    run_case(1, 150, 0, 2, "R7 remapped code 1");
    write_map(4, 6);
    run_case(4, 150, 0, 2, "R8 invalid entry");
    write_map(4, 3);

    // R9: glitch rejection with a short period so a wrong accept is visible
    run_case(7, 0, 0, 0, "R8 park");
    @(negedge clk);
    plen = 5;
    period_i = CNT_W'(plen - 1);
    filt_len_i = FILT_W'(8);
    run_case(1, 0, 0, 0, "R9 settle code 1");
    compute_exp(1, 0, 0, 0);
    @(negedge clk);
    hall_i = 3'd2;
    repeat (4) @(negedge clk);
    hall_i = 3'd1;
    bad = 0;
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      if (int'(hb_on_o) != e_hb) bad++;
    end
    check(bad == 0, "R9 short glitch ignored", bad, 0);
    run_case(2, 0, 0, 0, "R9 long change accepted");
    run_case(7, 0, 0, 0, "R8 park");
    @(negedge clk);
    plen = 50;
    period_i = CNT_W'(plen - 1);
    filt_len_i = FILT_W'(3);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int code, c, tq, ml;
      code = 1 + int'($urandom % 6);
      c = int'($urandom % 1024) - 512;
      tq = ($urandom % 4 == 0) ? 1 : 0;
      ml = int'($urandom % 7);
      run_case(code, c, tq, ml, "R2 R3 R4 R5 R6 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule